// File: doc/BRIEF.md
# Multilevel Indirect Address Resolver

The resolver turns a short address field into a final effective address by following a chain of pointers held in memory. After a start pulse it reads the word at the zero-extended field address. The top bit of every word it reads is a flag. When the flag is set, the other bits name the next word to read. When the flag is clear, the chain ends, and the address of that last word becomes the effective address. The resolver can therefore perform any number of dereference steps, up to a set limit, with no help from the sequencer that started it.

Memory is reached through a simple read port. A request pulse carries the address, and the data comes back later, marked by a valid strobe. The resolver never has more than one read in flight. A chain that is still pointing onward at the depth limit is cut off and reported as an error. The field is only `K` bits wide, so the first read can reach only the low `2^K` words. Pointers read from memory are `N-1` bits wide and can reach the whole word address space.

Top module: `indirect_resolver`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy_o`, `done_o`, `err_o` and `mem_req_o` are low and `ea_o` is zero.
- R2: A start pulse sampled while idle makes `mem_req_o` high in the next cycle. In that cycle `mem_addr_o` equals `field_i` zero-extended to `N-1` bits, so every chain makes at least one read.
- R3: When a returned word has bit `N-1` set, the next request is raised in the cycle after `mem_rvalid_i`. Its address is the word's bits `N-2:0`, which may lie outside the range the field can reach.
- R4: When a returned word has bit `N-1` clear, `done_o` rises in the next cycle. At the same time `err_o` is low and `ea_o` is the address that word was read from.
- R5: If read number `MAX_DEPTH` returns a word with bit `N-1` set, `done_o` and `err_o` rise together. No further read is made, and `ea_o` is the address of that last read. A chain whose final word is read number `MAX_DEPTH` ends without error.
- R6: `mem_req_o` is a one-cycle pulse. No new request is raised before the valid strobe for the previous one.
- R7: A start pulse that arrives while `busy_o` is high has no effect on the read sequence or on the result.
- R8: `done_o` lasts one cycle, and `busy_o` is already low during it.
- R9: `ea_o` holds its value from one completion until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin resolving `field_i` |
| field_i | input | K | Starting address field |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | N-1 | Read address |
| mem_rvalid_i | input | 1 | Read data valid strobe |
| mem_rdata_i | input | N | Read data; bit N-1 is the pointer flag |
| busy_o | output | 1 | A chain is being followed |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Depth limit hit, valid with `done_o` |
| ea_o | output | N-1 | Resolved effective address |

## Verification
The assertions assume that the memory raises `mem_rvalid_i` exactly once for each request. They also assume that it never raises the strobe in the cycle a request goes out, or while no read is pending. The bench memory model respects this. It captures each request, waits a chosen latency of one to three cycles and returns one strobe. Each run uses a single latency, so requests never overlap. The stray start pulses that the bench drives in the middle of a chain reach only the start input and never the memory side.

// File: rtl/iar_pkg.sv
package iar_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } iar_state_e;
endpackage

// File: rtl/iar_word_decode.sv
module iar_word_decode #(
  parameter int N = 16
) (
  input  logic [N-1:0] word_i,
  output logic         is_ptr_o,
  output logic [N-2:0] next_addr_o
);
  always_comb begin
    is_ptr_o    = word_i[N-1];
    next_addr_o = word_i[N-2:0];
  end
endmodule

// File: rtl/iar_depth_counter.sv
module iar_depth_counter #(
  parameter int MAX_DEPTH = 8,
  localparam int DW = $clog2(MAX_DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic step_i,
  output logic at_limit_o
);
  localparam logic [DW-1:0] LIMIT = DW'(MAX_DEPTH);
  localparam logic [DW-1:0] ONE   = DW'(1);

  logic [DW-1:0] level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
    end else if (load_i) begin
      level_q <= ONE;
    end else if (step_i) begin
      level_q <= level_q + ONE;
    end
  end

  always_comb at_limit_o = (level_q == LIMIT);

  // the read count never goes past the depth limit (R5)
  assert_depth_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    step_i |-> !at_limit_o);
endmodule

// File: rtl/indirect_resolver.sv
module indirect_resolver
  import iar_pkg::*;
#(
  parameter int K         = 6,
  parameter int N         = 16,
  parameter int MAX_DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [K-1:0] field_i,
  output logic         mem_req_o,
  output logic [N-2:0] mem_addr_o,
  input  logic         mem_rvalid_i,
  input  logic [N-1:0] mem_rdata_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         err_o,
  output logic [N-2:0] ea_o
);
  localparam int AW  = N - 1;
  localparam int PAD = AW - K;

  iar_state_e    state_q;
  logic          req_q, done_q, err_q;
  logic [AW-1:0] addr_q, ea_q;
  logic          is_ptr, at_limit, accept, step;
  logic [AW-1:0] next_addr, field_ext;

  always_comb begin
    field_ext = {{PAD{1'b0}}, field_i};
    accept    = (state_q == ST_IDLE) && start_i;
    step      = (state_q == ST_WAIT) && mem_rvalid_i && is_ptr && !at_limit;
  end

  iar_word_decode #(.N(N)) u_decode (
    .word_i      (mem_rdata_i),
    .is_ptr_o    (is_ptr),
    .next_addr_o (next_addr)
  );

  iar_depth_counter #(.MAX_DEPTH(MAX_DEPTH)) u_depth (
    .clk        (clk),
    .rst        (rst),
    .load_i     (accept),
    .step_i     (step),
    .at_limit_o (at_limit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      ea_q    <= '0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_WAIT;
            req_q   <= 1'b1;
            addr_q  <= field_ext;
          end
        end
        ST_WAIT: begin
          if (mem_rvalid_i) begin
            if (!is_ptr) begin
              done_q  <= 1'b1;
              ea_q    <= addr_q;
              state_q <= ST_IDLE;
            end else if (at_limit) begin
              done_q  <= 1'b1;
              err_q   <= 1'b1;
              ea_q    <= addr_q;
              state_q <= ST_IDLE;
            end else begin
              addr_q <= next_addr;
              req_q  <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o  = req_q;
    mem_addr_o = addr_q;
    busy_o     = (state_q != ST_IDLE);
    done_o     = done_q;
    err_o      = err_q;
    ea_o       = ea_q;
  end

  assert_first_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> (mem_req_o && mem_addr_o == {{PAD{1'b0}}, $past(field_i)}));

  assert_follow_pointer_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && mem_rvalid_i && mem_rdata_i[N-1] && !at_limit)
      |=> (mem_req_o && mem_addr_o == $past(mem_rdata_i[N-2:0])));

  assert_err_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o);

  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |=> !mem_req_o);

  assert_no_req_while_waiting_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !mem_rvalid_i && !mem_req_o) |=> !mem_req_o);

  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !mem_rvalid_i) |=> $stable(mem_addr_o));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_ea_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(ea_o));
endmodule

// File: tb/indirect_resolver_tb_top.sv
module indirect_resolver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int K = 6;
  localparam int N = 16;
  localparam int MAX_DEPTH = 8;

  // {field[5:0], expected ea[14:0], expected err, expected read count[3:0]}
  localparam int NV = 7;
  localparam logic [25:0] VEC [NV] = '{
    {6'd5,  15'd5,   1'b0, 4'd1},
    {6'd10, 15'd20,  1'b0, 4'd3},
    {6'd40, 15'd47,  1'b0, 4'd8},
    {6'd50, 15'd57,  1'b1, 4'd8},
    {6'd60, 15'd60,  1'b1, 4'd8},
    {6'd63, 15'd255, 1'b0, 4'd2},
    {6'd0,  15'd0,   1'b0, 4'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [K-1:0] field_i = '0;
  logic mem_req_o, mem_rvalid_i, busy_o, done_o, err_o;
  logic [N-2:0] mem_addr_o, ea_o;
  logic [N-1:0] mem_rdata_i;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  indirect_resolver #(.K(K), .N(N), .MAX_DEPTH(MAX_DEPTH)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .field_i(field_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .ea_o(ea_o)
  );

  // memory model: one response per request after lat cycles
  logic [15:0] mem [256];
  int lat = 1;
  logic pend = 1'b0;
  int cnt = 0;
  logic [N-2:0] paddr = '0;
  int nreq = 0;
  logic [N-2:0] first_addr = '0;
  int overlap = 0;

  initial begin
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = '0;
  end

  always @(posedge clk) begin
    mem_rvalid_i <= 1'b0;
    if (rst) begin
      pend <= 1'b0;
    end else if (mem_req_o) begin
      if (pend) overlap <= overlap + 1;
      pend  <= 1'b1;
      cnt   <= lat - 1;
      paddr <= mem_addr_o;
      if (nreq == 0) first_addr <= mem_addr_o;
      nreq <= nreq + 1;
    end else if (pend) begin
      if (cnt == 0) begin
        mem_rvalid_i <= 1'b1;
        mem_rdata_i  <= mem[paddr[7:0]];
        pend <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [K-1:0] f);
    @(negedge clk);
    nreq = 0;
    field_i = f;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int t;
    t = 0;
    while (!done_o && t < 200) begin
      @(negedge clk);
      t++;
    end
    ok = done_o;
  endtask

  task automatic run_vec(input logic [25:0] v, input int l, input bit poke);
    bit ok;
    logic [K-1:0] f;
    f = v[25:20];
    lat = l;
    launch(f);
    if (poke) begin
      repeat (3) @(negedge clk);
      field_i = 6'd5;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_done(ok);
    chk(ok, "R4", "done seen", int'(ok), 1);
    chk(first_addr == {9'd0, f}, "R2", "first read address", int'(first_addr), int'(f));
    chk(ea_o == v[19:5], "R4/R5", "ea", int'(ea_o), int'(v[19:5]));
    chk(err_o == v[4], "R5", "err", int'(err_o), int'(v[4]));
    chk(nreq == int'(v[3:0]), "R3/R5", "read count", nreq, int'(v[3:0]));
    chk(!busy_o, "R8", "busy during done", int'(busy_o), 0);
    chk(overlap == 0, "R6", "overlapping requests", overlap, 0);
    @(negedge clk);
    chk(!done_o, "R8", "done width", int'(done_o), 0);
    if (poke) chk(nreq == 8 && ea_o == 15'd47, "R7", "busy start ignored", int'(ea_o), 47);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [N-2:0] held;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[5]   = 16'h0123;
    mem[10]  = 16'h80C8;
    mem[200] = 16'h8014;
    mem[20]  = 16'h0777;
    for (int i = 0; i < 7; i++) mem[40+i] = 16'h8000 | 16'(41 + i);
    mem[47]  = 16'h0055;
    for (int i = 0; i < 8; i++) mem[50+i] = 16'h8000 | 16'(51 + i);
    mem[58]  = 16'h0011;
    mem[60]  = 16'h803C;
    mem[63]  = 16'h80FF;
    mem[255] = 16'h0000;
    mem[0]   = 16'h7FFF;

    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !err_o && !mem_req_o && ea_o == '0, "R1",
        "state in reset", int'(busy_o) + int'(done_o) + int'(err_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !err_o && !mem_req_o && ea_o == '0, "R1",
        "state after reset", int'(ea_o), 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], (i % 3) + 1, 1'b0);

    // R9: result holds while idle and no stray requests appear
    held = ea_o;
    nreq = 0;
    repeat (10) @(negedge clk);
    chk(ea_o == held, "R9", "ea hold", int'(ea_o), int'(held));
    chk(nreq == 0, "R6", "requests while idle", nreq, 0);

    // R7: start pulse during a long chain
    run_vec(VEC[2], 2, 1'b1);

    // R1: reset in the middle of a chain
    lat = 3;
    launch(6'd50);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(!busy_o && !done_o && !err_o && !mem_req_o && ea_o == '0, "R1",
        "mid-chain reset", int'(busy_o), 0);
    repeat (4) @(negedge clk);
    run_vec(VEC[1], 1, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule